// File: doc/BRIEF.md
# Dual-Direction Latched/Clocked Bus Transceiver

This block couples two data ports, A and B, through two independent one-way paths. Each path has one storage word that works as a transparent latch, a held latch or an edge-triggered register. The choice depends on two controls for that path: a latch enable, and a path clock that is sampled as a level. Each path also has an output enable. The A-to-B enable is active high and the B-to-A enable is active low. A disabled port raises no drive enables and presents zeros on its data output.

Each port is split into a data input vector, a data output vector and a per-bit drive-enable vector. A pad ring or a simulation wrapper can therefore form a tri-state bus from them. The path clocks are ordinary inputs. They are sampled on the block clock `clk`, and a rising edge counts when the path clock is seen low at one `clk` edge and high at the next. The storage words have no reset. Only the edge detectors are reset, and they are reset to "clock seen high" so that no edge is detected while reset is active.

Top module: `bus_xcvr`

## Requirements
- R1: While a path's latch enable is 1 and its output is enabled, the output equals the live input of the opposite port in the same cycle, with no register delay.
- R2: While the latch enable is 0 and the path clock stays at a constant level (0 or 1), the stored word and the enabled output do not change, whatever the input does.
- R3: While the latch enable is 0, a rising path clock captures the input present at that `clk` edge. The enabled output shows the captured word from that edge on, and it keeps showing it while the clock stays high.
- R4: The A-to-B output enable is active high. When it is 0, `b_drive_en` is all zeros and `b_out` is all zeros, whatever the other inputs are.
- R5: The B-to-A output enable is active low. When it is 1, `a_drive_en` is all zeros and `a_out` is all zeros. When it is 0, the A port is driven.
- R6: When the latch enable falls, the output holds the input that was present at the last `clk` edge at which the latch enable was still 1.
- R7: A rising path clock while the latch enable is 1 does not break transparency. The output keeps tracking the live input, and once the latch enable falls the held word is the last transparent input.
- R8: Each drive-enable vector is all ones or all zeros, following its own path's enable. The two paths operate independently in the same cycle.
- R9: While `rst_n` is 0, a path clock that goes high is not treated as a rising edge, and the stored word is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; path controls are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the edge detectors |
| a_in | input | W | Data arriving on the A port |
| b_in | input | W | Data arriving on the B port |
| ab_le | input | 1 | A-to-B latch enable, 1 = transparent |
| ab_clk | input | 1 | A-to-B path clock, captured on a rising level change |
| ab_oe | input | 1 | A-to-B output enable, active high |
| ba_le | input | 1 | B-to-A latch enable, 1 = transparent |
| ba_clk | input | 1 | B-to-A path clock, captured on a rising level change |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| b_out | output | W | Data driven toward the B port (zero when disabled) |
| b_drive_en | output | W | Per-bit drive enable for the B port |
| a_out | output | W | Data driven toward the A port (zero when disabled) |
| a_drive_en | output | W | Per-bit drive enable for the A port |

## Verification
Within one path, the latch enable and a rising path clock can arrive in the same cycle. The bench forces this by toggling the path clock while the latch enable is high and the input changes each cycle. The output is expected to track the live input, and the word held after the latch enable falls must be the last transparent value rather than a word captured by the clock. Across the two paths, a capture on one side and a tri-state or transparent phase on the other are driven in the same cycles. A behavioural model updated on every `clk` edge judges both sides on every cycle.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  typedef enum logic [1:0] {
    XFER_PASS = 2'd0,
    XFER_HOLD = 2'd1,
    XFER_LOAD = 2'd2
  } xfer_mode_e;

  function automatic xfer_mode_e pick_mode(input logic le, input logic rise);
    if (le)        return XFER_PASS;
    else if (rise) return XFER_LOAD;
    else           return XFER_HOLD;
  endfunction

endpackage

// File: rtl/xcvr_rise_det.sv
module xcvr_rise_det (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic rise
);

  logic seen_q;
  logic seen_d;

  always_comb begin
    seen_d = level;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b1;
    else        seen_q <= seen_d;
  end

  assign rise = rst_n & level & ~seen_q;

  // R3: a detected edge cannot repeat on the following cycle
  assert_single_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);

endmodule

// File: rtl/xcvr_path.sv
module xcvr_path
  import xcvr_pkg::*;
#(
  parameter int W             = 18,
  parameter bit OE_ACTIVE_LOW = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] data_in,
  input  logic         le,
  input  logic         pclk,
  input  logic         oe_raw,
  output logic [W-1:0] data_out,
  output logic [W-1:0] drive_en
);

  logic       rise;
  logic       oe_on;
  xfer_mode_e mode;
  logic [W-1:0] store_q;
  logic [W-1:0] store_d;
  logic         store_we;

  xcvr_rise_det u_rise (
    .clk   (clk),
    .rst_n (rst_n),
    .level (pclk),
    .rise  (rise)
  );

  generate
    if (OE_ACTIVE_LOW) begin : g_oe_low
      assign oe_on = ~oe_raw;
    end else begin : g_oe_high
      assign oe_on = oe_raw;
    end
  endgenerate

  always_comb begin
    mode     = pick_mode(le, rise);
    store_we = (mode != XFER_HOLD);
    store_d  = store_we ? data_in : store_q;
  end

  always_ff @(posedge clk) begin
    if (store_we) store_q <= store_d;
  end

  always_comb begin
    drive_en = {W{oe_on}};
    if (!oe_on)          data_out = '0;
    else if (le)         data_out = data_in;
    else                 data_out = store_q;
  end

  // R6: a transparent cycle leaves the storage equal to that input
  assert_pass_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
    le |=> store_q == $past(data_in));

  // R2: no latch enable and no edge -> storage unchanged
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!le && !rise) |=> $stable(store_q));

  // R3: edge with latch enable low captures the input
  assert_edge_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!le && rise) |=> store_q == $past(data_in));

  // R4 / R5: an undriven port shows zeros
  assert_quiet_when_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_en == '0) |-> (data_out == '0));

endmodule

// File: rtl/bus_xcvr.sv
module bus_xcvr #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         ab_le,
  input  logic         ab_clk,
  input  logic         ab_oe,
  input  logic         ba_le,
  input  logic         ba_clk,
  input  logic         ba_oe_n,
  output logic [W-1:0] b_out,
  output logic [W-1:0] b_drive_en,
  output logic [W-1:0] a_out,
  output logic [W-1:0] a_drive_en
);

  xcvr_path #(.W(W), .OE_ACTIVE_LOW(1'b0)) u_ab (
    .clk      (clk),
    .rst_n    (rst_n),
    .data_in  (a_in),
    .le       (ab_le),
    .pclk     (ab_clk),
    .oe_raw   (ab_oe),
    .data_out (b_out),
    .drive_en (b_drive_en)
  );

  xcvr_path #(.W(W), .OE_ACTIVE_LOW(1'b1)) u_ba (
    .clk      (clk),
    .rst_n    (rst_n),
    .data_in  (b_in),
    .le       (ba_le),
    .pclk     (ba_clk),
    .oe_raw   (ba_oe_n),
    .data_out (a_out),
    .drive_en (a_drive_en)
  );

  // R8: drive enables are all-or-nothing on each side
  assert_uniform_en_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(b_drive_en) == 0 || $countones(b_drive_en) == W) &&
    ($countones(a_drive_en) == 0 || $countones(a_drive_en) == W));

endmodule

// File: tb/bus_xcvr_tb.sv
module bus_xcvr_tb;

  localparam int W = 18;

  logic clk = 1'b0;
  logic rst_n;
  logic [W-1:0] a_in, b_in;
  logic ab_le, ab_clk, ab_oe, ba_le, ba_clk, ba_oe_n;
  logic [W-1:0] b_out, b_drive_en, a_out, a_drive_en;

  int n_chk = 0;
  int n_bad = 0;

  // behavioural reference state
  logic [W-1:0] m_ab, m_ba;
  bit known_ab = 0, known_ba = 0;
  bit prv_ab = 1, prv_ba = 1;

  always #2 clk = ~clk;

  bus_xcvr #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
    .ab_le(ab_le), .ab_clk(ab_clk), .ab_oe(ab_oe),
    .ba_le(ba_le), .ba_clk(ba_clk), .ba_oe_n(ba_oe_n),
    .b_out(b_out), .b_drive_en(b_drive_en),
    .a_out(a_out), .a_drive_en(a_drive_en)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // reference update at each block clock edge
  always @(posedge clk) begin
    bit r_ab, r_ba;
    r_ab = rst_n && ab_clk && !prv_ab;
    r_ba = rst_n && ba_clk && !prv_ba;
    if (ab_le || r_ab) begin m_ab = a_in; known_ab = 1; end
    if (ba_le || r_ba) begin m_ba = b_in; known_ba = 1; end
    prv_ab = rst_n ? ab_clk : 1'b1;
    prv_ba = rst_n ? ba_clk : 1'b1;
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      chk("R8 b_drive_en", b_drive_en, {W{ab_oe}});
      chk("R8 a_drive_en", a_drive_en, {W{~ba_oe_n}});
      if (!ab_oe)     chk("R4 b_out off", b_out, '0);
      else if (ab_le) chk("R1 b_out pass", b_out, a_in);
      else if (known_ab) chk("R2/R3 b_out stored", b_out, m_ab);
      if (ba_oe_n)    chk("R5 a_out off", a_out, '0);
      else if (ba_le) chk("R1 a_out pass", a_out, b_in);
      else if (known_ba) chk("R2/R3 a_out stored", a_out, m_ba);
    end
  end

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [W-1:0] v1, v2, hold_v;
    rst_n = 0; a_in = '0; b_in = '0;
    ab_le = 0; ab_clk = 1; ab_oe = 0;
    ba_le = 0; ba_clk = 1; ba_oe_n = 1;
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R4 reset b_drive_en", b_drive_en, '0);
    chk("R5 reset a_drive_en", a_drive_en, '0);
    #1;

    // R1 transparent on both sides
    ab_oe = 1; ba_oe_n = 0; ab_le = 1; ba_le = 1;
    for (int i = 0; i < 6; i++) begin
      a_in = W'($urandom); b_in = W'($urandom);
      @(negedge clk);
      chk("R1 b_out", b_out, a_in);
      chk("R1 a_out", a_out, b_in);
      #1;
    end

    // R6 latch enable falls while input changes
    v1 = 18'h2A5C3; a_in = v1; @(negedge clk); #1;
    ab_le = 0; a_in = 18'h1111F;
    @(negedge clk);
    chk("R6 held after le fall", b_out, v1);
    #1;

    // R2 static clock high then low
    for (int i = 0; i < 3; i++) begin
      a_in = W'($urandom); @(negedge clk);
      chk("R2 hold clk high", b_out, v1); #1;
    end
    ab_clk = 0;
    for (int i = 0; i < 3; i++) begin
      a_in = W'($urandom); @(negedge clk);
      chk("R2 hold clk low", b_out, v1); #1;
    end

    // R3 rising clock captures
    v2 = 18'h3C0F0; ab_clk = 1; a_in = v2;
    @(negedge clk);
    chk("R3 captured", b_out, v2); #1;
    a_in = 18'h00ABC; @(negedge clk);
    chk("R3 stays while clk high", b_out, v2); #1;

    // R4 disable ignores data and mode
    ab_oe = 0; ab_le = 1; a_in = 18'h3FFFF;
    @(negedge clk);
    chk("R4 off b_out", b_out, '0);
    chk("R4 off b_drive_en", b_drive_en, '0); #1;
    ab_oe = 1;

    // R7 clock edges during transparency
    ab_clk = 0;
    for (int i = 0; i < 6; i++) begin
      ab_clk = ~ab_clk; a_in = W'($urandom); hold_v = a_in;
      @(negedge clk);
      chk("R7 pass during edge", b_out, a_in); #1;
    end
    ab_le = 0; a_in = 18'h05A5A;
    @(negedge clk);
    chk("R7 held last transparent", b_out, hold_v); #1;

    // R8 mixed: B-to-A captures while A-to-B off; then swap
    ab_oe = 0; ba_le = 0; ba_clk = 0; b_in = 18'h12345; @(negedge clk); #1;
    ba_clk = 1; b_in = 18'h2BCDE; @(negedge clk);
    chk("R8 ba capture", a_out, 18'h2BCDE);
    chk("R8 ab quiet", b_out, '0); #1;
    ab_oe = 1; ab_le = 1; ba_oe_n = 1; a_in = 18'h0F0F0;
    @(negedge clk);
    chk("R8 ab pass", b_out, 18'h0F0F0);
    chk("R5 a_out off", a_out, '0); #1;
    ba_oe_n = 0;

    // R9 no edge during reset
    ab_le = 1; a_in = 18'h15555; @(negedge clk); #1;
    ab_le = 0; ab_clk = 0; @(negedge clk); #1;
    rst_n = 0; ab_clk = 1; a_in = 18'h2AAAA;
    @(negedge clk); #1;
    rst_n = 1; @(negedge clk);
    chk("R9 no capture in reset", b_out, 18'h15555); #1;

    // random mixed traffic judged by the model
    for (int i = 0; i < 400; i++) begin
      a_in = W'($urandom); b_in = W'($urandom);
      ab_le = ($urandom % 4) == 0; ba_le = ($urandom % 4) == 0;
      ab_clk = $urandom; ba_clk = $urandom;
      ab_oe = ($urandom % 5) != 0; ba_oe_n = ($urandom % 5) == 0;
      @(negedge clk); #1;
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule